// File: doc/BRIEF.md
# One-Hot-of-Four Handshake Link

This block carries a packet stream of bytes between two clocked endpoints across a six-wire link that behaves like a delay-insensitive channel. The sending end accepts bytes, each with an end-of-packet marker, on a valid/ready port. It splits every byte into 2-bit symbols. Each symbol raises exactly one of four rail wires, and the rail index equals the bit pair's value. A fifth forward wire marks the packet boundary. A single acknowledge wire runs back from the receiving end and paces each symbol through a four-phase, return-to-zero exchange.

The receiving end decodes the rails and rebuilds each byte. It holds a completed byte until the next symbol shows whether that byte closed its packet, then presents the byte with the correct end marker on a valid/ready port. Forward and acknowledge wires pass through parameterised delay stages, which model arbitrary wire latency. Because each edge waits on the far side's reply, correctness does not depend on those latencies. The receiver holds back its acknowledge when its output cannot accept data, so backpressure reaches the sender through the handshake alone.

Top module: `quad_rail_link`

## Requirements
- R1: At any cycle, at most one of the five forward wires (four rails plus the boundary wire) is high. A data symbol with 2-bit value v raises rail bit v only.
- R2: A byte goes out as DATA_W/2 symbols. The first symbol carries bits [1:0], the next carries bits [3:2], and so on up to the top pair.
- R3: After the symbols of a byte flagged as end-of-packet, exactly one boundary symbol follows, with the boundary wire high and all rails low. No boundary symbol follows any other byte.
- R4: The sender holds a raised symbol unchanged until it sees acknowledge high. It then drives all forward wires low and keeps them low until it sees acknowledge low.
- R5: The receiver raises acknowledge only in the cycle after it captures a valid symbol. It keeps acknowledge high while any forward wire is high and drops it one cycle after it sees all forward wires low.
- R6: Bytes leave the receiver in the order sent, with no loss or duplication. The last flag is 1 exactly on the final byte of each packet.
- R7: While the output holds an undelivered byte and outReady is low, the output data and flag stay stable. A symbol that needs the output slot is left unacknowledged, so the sender stalls with the symbol on the wires.
- R8: If two or more forward wires are high together, protoErr goes to 1 on the next edge and stays at 1 until reset.
- R9: The behaviour in R1 to R7 holds for any forward-latency and acknowledge-latency settings.
- R10: After reset, inReady is 1, and outValid, acknowledge, all forward wires and protoErr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | DATA_W | Byte offered to the sender |
| inLast | input | 1 | Marks the final byte of a packet |
| inValid | input | 1 | Input byte present |
| inReady | output | 1 | Sender takes the byte on this edge |
| outData | output | DATA_W | Byte rebuilt by the receiver |
| outLast | output | 1 | Final byte of its packet |
| outValid | output | 1 | Output byte present |
| outReady | input | 1 | Consumer takes the output byte |
| linkRails | output | 4 | Rail wires as driven by the sender |
| linkCtl | output | 1 | Boundary wire as driven by the sender |
| linkAck | output | 1 | Acknowledge as driven by the receiver |
| protoErr | output | 1 | Sticky multi-wire error flag of the receiver |

## Verification
The bench builds the link with DATA_W=8, three cycles of forward latency and two of acknowledge latency. These unequal, non-zero delays put real distance between each edge and its reply, so any sender that races ahead of the acknowledge, or any receiver that drops acknowledge before the rails clear, loses or repeats symbols that the symbol model detects. A second, standalone receiver at DATA_W=8 is driven directly on its rails. This reaches the multi-wire error and exact acknowledge timing, which the paired sender can never produce.

// File: rtl/qrl_pkg.sv
package qrl_pkg;

  // Strobes from the sender control to the sender datapath
  typedef struct packed {
    logic load;    // take a new byte from the input port
    logic shift;   // advance to the next bit pair
    logic selCtl;  // switch to the boundary symbol
    logic drive;   // put the current symbol on the wires
  } txStrobe_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_RTZ  = 2'd2
  } txState_t;

endpackage

// File: rtl/qrl_delay.sv
module qrl_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dOut = dIn;
    end else begin : g_pipe
      logic [WIDTH-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= dIn;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign dOut = stage[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/qrl_tx_path.sv
module qrl_tx_path
  import qrl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic [3:0]        rails,
  output logic              ctl,
  output logic              lastSym,
  output logic              pktLast,
  output logic              ctlPhase
);

  localparam int SYMS  = DATA_W / 2;
  localparam int IDX_W = (SYMS > 1) ? $clog2(SYMS) : 1;

  logic [DATA_W-1:0] shiftReg;
  logic [IDX_W-1:0]  symIdx;
  logic              lastReg;
  logic              ctlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      symIdx   <= '0;
      lastReg  <= 1'b0;
      ctlReg   <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= inData;
      symIdx   <= '0;
      lastReg  <= inLast;
      ctlReg   <= 1'b0;
    end else begin
      if (strb.shift) begin
        shiftReg <= shiftReg >> 2;
        symIdx   <= symIdx + 1'b1;
      end
      if (strb.selCtl) ctlReg <= 1'b1;
    end
  end

  assign lastSym  = (symIdx == IDX_W'(SYMS - 1));
  assign pktLast  = lastReg;
  assign ctlPhase = ctlReg;
  assign rails    = (strb.drive && !ctlReg) ? (4'b0001 << shiftReg[1:0]) : 4'b0000;
  assign ctl      = strb.drive && ctlReg;

  // R1: never more than one forward wire high
  p_one_wire_r1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl, rails}) <= 1);

endmodule

// File: rtl/qrl_tx_ctrl.sv
module qrl_tx_ctrl
  import qrl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      ackIn,
  input  logic      lastSym,
  input  logic      pktLast,
  input  logic      ctlPhase,
  output logic      inReady,
  output txStrobe_t strb
);

  txState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= TX_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    inReady   = (state == TX_IDLE);
    unique case (state)
      TX_IDLE: if (inValid) begin
        strb.load = 1'b1;
        nextState = TX_SEND;
      end
      TX_SEND: begin
        strb.drive = 1'b1;
        if (ackIn) nextState = TX_RTZ;
      end
      TX_RTZ: if (!ackIn) begin
        if (ctlPhase) begin
          nextState = TX_IDLE;
        end else if (!lastSym) begin
          strb.shift = 1'b1;
          nextState  = TX_SEND;
        end else if (pktLast) begin
          strb.selCtl = 1'b1;
          nextState   = TX_SEND;
        end else begin
          nextState = TX_IDLE;
        end
      end
      default: nextState = TX_IDLE;
    endcase
  end

  // R4: a symbol is never withdrawn before the acknowledge arrives
  p_wait_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && !ackIn) |=> strb.drive);

endmodule

// File: rtl/qrl_rx.sv
module qrl_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rails,
  input  logic              ctl,
  input  logic              outReady,
  output logic              ack,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outValid,
  output logic              protoErr
);

  localparam int SYMS  = DATA_W / 2;
  localparam int IDX_W = (SYMS > 1) ? $clog2(SYMS) : 1;

  logic [DATA_W-1:0] accum, pendData, nextByte;
  logic [IDX_W-1:0]  symIdx;
  logic              pendValid;
  logic [4:0]        hot;
  logic              anyHigh, single, multi, outFree, needOut, capture, push;
  logic [1:0]        symVal;

  assign hot     = {ctl, rails};
  assign anyHigh = |hot;
  assign multi   = (hot & (hot - 5'd1)) != 5'd0;
  assign single  = anyHigh && !multi;
  assign outFree = !outValid || outReady;
  assign needOut = ctl || (symIdx == '0 && pendValid);
  assign capture = !ack && single && (!needOut || outFree);
  assign push    = capture && needOut && pendValid;

  always_comb begin
    symVal = 2'd0;
    for (int i = 0; i < 4; i++) if (rails[i]) symVal = 2'(i);
  end

  assign nextByte = {symVal, accum[DATA_W-1:2]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ack       <= 1'b0;
      accum     <= '0;
      symIdx    <= '0;
      pendValid <= 1'b0;
      pendData  <= '0;
      outValid  <= 1'b0;
      outData   <= '0;
      outLast   <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      if (multi) protoErr <= 1'b1;
      if (outValid && outReady) outValid <= 1'b0;
      if (push) begin
        outValid <= 1'b1;
        outData  <= pendData;
        outLast  <= ctl;
      end
      if (capture) begin
        ack <= 1'b1;
        if (ctl) begin
          pendValid <= 1'b0;
        end else begin
          accum <= nextByte;
          if (symIdx == '0) pendValid <= 1'b0;
          if (symIdx == IDX_W'(SYMS - 1)) begin
            pendData  <= nextByte;
            pendValid <= 1'b1;
            symIdx    <= '0;
          end else begin
            symIdx <= symIdx + 1'b1;
          end
        end
      end else if (ack && !anyHigh) begin
        ack <= 1'b0;
      end
    end
  end

  // R5: acknowledge rises only after a symbol was present
  p_ack_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> $past(anyHigh));
  // R5: acknowledge held while any forward wire is still high
  p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ack && anyHigh) |=> ack);
  // R7: a stalled output keeps its contents
  p_out_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));
  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

endmodule

// File: rtl/quad_rail_link.sv
module quad_rail_link
  import qrl_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FWD_LAT = 1,
  parameter int ACK_LAT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [3:0]        linkRails,
  output logic              linkCtl,
  output logic              linkAck,
  output logic              protoErr
);

  txStrobe_t strb;
  logic       lastSym, pktLast, ctlPhase;
  logic [3:0] txRails;
  logic       txCtl, txAck, rxAck;
  logic [4:0] rxFwd;

  qrl_tx_ctrl u_txCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ackIn(txAck),
    .lastSym(lastSym), .pktLast(pktLast), .ctlPhase(ctlPhase),
    .inReady(inReady), .strb(strb)
  );

  qrl_tx_path #(.DATA_W(DATA_W)) u_txPath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .inLast(inLast),
    .rails(txRails), .ctl(txCtl), .lastSym(lastSym), .pktLast(pktLast),
    .ctlPhase(ctlPhase)
  );

  qrl_delay #(.WIDTH(5), .DEPTH(FWD_LAT)) u_fwdDly (
    .clk(clk), .rstN(rstN), .dIn({txCtl, txRails}), .dOut(rxFwd)
  );

  qrl_delay #(.WIDTH(1), .DEPTH(ACK_LAT)) u_ackDly (
    .clk(clk), .rstN(rstN), .dIn(rxAck), .dOut(txAck)
  );

  qrl_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rstN(rstN), .rails(rxFwd[3:0]), .ctl(rxFwd[4]),
    .outReady(outReady), .ack(rxAck), .outData(outData), .outLast(outLast),
    .outValid(outValid), .protoErr(protoErr)
  );

  assign linkRails = txRails;
  assign linkCtl   = txCtl;
  assign linkAck   = rxAck;

  // R4: a raised symbol does not change before the acknowledge is seen
  p_sym_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|{txCtl, txRails}) && !txAck) |=> $stable({txCtl, txRails}));
  // R4: once acknowledged, forward wires return to zero
  p_rtz_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|{txCtl, txRails}) && txAck) |=> ({txCtl, txRails} == 5'd0));

endmodule

// File: tb/quad_rail_link_bench.sv
module quad_rail_link_bench;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inLast = 1'b0, inValid = 1'b0, inReady;
  logic [DW-1:0] outData;
  logic          outLast, outValid, outReady = 1'b0;
  logic [3:0]    linkRails;
  logic          linkCtl, linkAck, protoErr;

  // standalone receiver, driven directly on its rails
  logic [3:0]    rxRails = '0;
  logic          rxCtl = 1'b0, rxOutReady = 1'b1;
  logic          rxAck, rxOutLast, rxOutValid, rxErr;
  logic [DW-1:0] rxOutData;

  int errors = 0, checks = 0, cycles = 0;
  bit holdOff = 1'b0, monOn = 1'b0;
  logic [8:0] expBytes[$];   // {last, data}
  logic [4:0] expSyms[$];    // {ctl, rails}
  logic [4:0] prevWires = '0;

  always #2 clk = ~clk;  // 250 MHz

  // R9: unequal, non-zero wire latencies
  quad_rail_link #(.DATA_W(DW), .FWD_LAT(3), .ACK_LAT(2)) u_quad_rail_link (
    .clk(clk), .rstN(rstN), .inData(inData), .inLast(inLast), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outLast(outLast), .outValid(outValid),
    .outReady(outReady), .linkRails(linkRails), .linkCtl(linkCtl),
    .linkAck(linkAck), .protoErr(protoErr)
  );

  qrl_rx #(.DATA_W(DW)) u_rx (
    .clk(clk), .rstN(rstN), .rails(rxRails), .ctl(rxCtl), .outReady(rxOutReady),
    .ack(rxAck), .outData(rxOutData), .outLast(rxOutLast), .outValid(rxOutValid),
    .protoErr(rxErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference model: expected symbols and bytes, compared every clock
  always @(negedge clk) begin
    logic [4:0] cur, e;
    logic [8:0] b;
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finishRun();
    end
    if (monOn) begin
      outReady = holdOff ? 1'b0 : ($urandom % 4 != 0);
      cur = {linkCtl, linkRails};
      if (cur != 5'd0 && prevWires == 5'd0) begin
        check($countones(cur) == 1, "R1 one wire", 32'(cur), 32'd1);
        e = (expSyms.size() > 0) ? expSyms.pop_front() : 5'h1f;
        check(cur == e, "R2 R3 symbol order", 32'(cur), 32'(e));
      end else if (cur != 5'd0 && prevWires != 5'd0) begin
        check(cur == prevWires, "R4 symbol held", 32'(cur), 32'(prevWires));
      end
      prevWires = cur;
      if (outValid && outReady) begin
        b = (expBytes.size() > 0) ? expBytes.pop_front() : 9'h1ff;
        check({outLast, outData} == b, "R6 R9 byte and last", 32'({outLast, outData}), 32'(b));
      end
      check(protoErr == 1'b0, "R8 no error on clean link", 32'(protoErr), 32'd0);
    end
  end

  task automatic sendByte(input logic [7:0] d, input bit last);
    inData  = d;
    inLast  = last;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    for (int k = 0; k < DW / 2; k++) expSyms.push_back(5'(4'b0001 << d[2*k +: 2]));
    if (last) expSyms.push_back(5'b10000);
    expBytes.push_back({last, d});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendPacket(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) sendByte(seed + 8'(i * 37), i == len - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(inReady == 1'b1, "R10 inReady", 32'(inReady), 32'd1);
    check(outValid == 1'b0, "R10 outValid", 32'(outValid), 32'd0);
    check({linkCtl, linkRails, linkAck} == 6'd0, "R10 wires", 32'({linkCtl, linkRails, linkAck}), 32'd0);
    check(protoErr == 1'b0, "R10 protoErr", 32'(protoErr), 32'd0);
    monOn = 1'b1;

    sendPacket(1, 8'h00);
    sendPacket(3, 8'hE4);
    sendPacket(2, 8'hFF);
    sendPacket(4, 8'h1B);

    // R7: stall the output, then release
    while (expBytes.size() > 0) @(negedge clk);
    holdOff = 1'b1;
    sendPacket(3, 8'h5A);
    repeat (200) @(negedge clk);
    check(outValid == 1'b1 && outData == 8'h5A, "R7 first byte held", 32'(outData), 32'h5A);
    check(linkAck == 1'b0, "R7 ack withheld", 32'(linkAck), 32'd0);
    check(linkRails != 4'd0, "R7 symbol stalled on wires", 32'(linkRails), 32'd1);
    check(inReady == 1'b0, "R7 sender stalled", 32'(inReady), 32'd0);
    holdOff = 1'b0;
    while (expBytes.size() > 0 || expSyms.size() > 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(expSyms.size() == 0, "R3 no extra symbols", 32'(expSyms.size()), 32'd0);

    // R5: standalone receiver acknowledge timing
    rxRails = 4'b0100;
    @(negedge clk);
    check(rxAck == 1'b1, "R5 ack after capture", 32'(rxAck), 32'd1);
    repeat (2) @(negedge clk);
    check(rxAck == 1'b1, "R5 ack held while wire high", 32'(rxAck), 32'd1);
    rxRails = 4'b0000;
    @(negedge clk);
    check(rxAck == 1'b0, "R5 ack released", 32'(rxAck), 32'd0);
    check(rxErr == 1'b0, "R8 clean symbol no error", 32'(rxErr), 32'd0);

    // R8: two wires high together
    rxRails = 4'b0011;
    @(negedge clk);
    check(rxErr == 1'b1, "R8 error raised", 32'(rxErr), 32'd1);
    check(rxAck == 1'b0, "R8 no ack for invalid symbol", 32'(rxAck), 32'd0);
    rxRails = 4'b0000;
    repeat (3) @(negedge clk);
    check(rxErr == 1'b1, "R8 error sticky", 32'(rxErr), 32'd1);

    finishRun();
  end

endmodule